// File: doc/BRIEF.md
# Page-mode memory access timer

This block works out how many CPU cycles each memory access takes on a bus whose memory is organised in 256-byte pages. The core hands it one access at a time: what kind of access it is (opcode fetch, data read or data write), the address, and which memory region the address decodes to. The block remembers which page is open and what kind of access opened it. It charges one cycle when the access stays in that page with the same kind, and two cycles when a new page must be opened. Internal ROM and the external slot have fixed costs that do not depend on paging. The core can also force a page break, for example after an absolute jump. It can ask for one leading idle cycle in which no bus transfer takes place.

While an access is in progress the block holds `busy` high and raises `xfer` in every cycle that carries a bus transfer. It pulses `done` in the final cycle. A new request is taken only when the block is idle, so the earliest next acceptance comes in the cycle after `done`. Instruction decode, refresh and real DRAM strobes are left to other logic. This block keeps only the cycle budget.

Top module: `pm_access_timer`

## Requirements
- R1: After reset `busy`, `done` and `xfer` are low and no page is open, so the first RAM access costs 2 cycles.
- R2: A RAM access whose upper address byte (bits 15:8) matches the open page, and whose access class matches the class that opened it, costs 1 cycle. This holds even when the fetch address is not sequential. Classes are: kind 0 = fetch, kind 1 = read, kinds 2 and 3 = write.
- R3: A RAM access to a different page than the open one costs 2 cycles and makes its page the open page.
- R4: A change of access class costs 2 cycles even inside the same page. This covers fetch to data, data to fetch, read to write and write to read.
- R5: When `force_break` is high with the request, the access costs 2 cycles even if it would otherwise be a hit.
- R6: Region 2 (internal ROM) always costs ROM_CYC cycles (default 3) and leaves the open-page state untouched.
- R7: Region 1 (internal ROM in DRAM mode) follows exactly the same rules as region 0 (RAM) and shares the same open-page state.
- R8: Region 3 (external slot) costs EXT_CYC cycles and closes the open page, so the next RAM access costs 2 cycles.
- R9: `req_extra` adds one idle cycle at the start of the access. In that cycle `busy` is high and `xfer` is low.
- R10: `done` is high for exactly one cycle, the last busy cycle. A request presented while `busy` is high is ignored.
- R11: `xfer` is high in exactly the busy cycles that are not the extra idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when not busy |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 treated as write |
| req_addr | input | 16 | Access address |
| req_region | input | 2 | 0 RAM, 1 ROM in DRAM mode, 2 internal ROM, 3 external slot |
| req_extra | input | 1 | Insert one leading idle cycle |
| force_break | input | 1 | Charge a page break regardless of hit |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final cycle of the access |
| xfer | output | 1 | Bus transfer cycle |

## Verification
The bench instantiates the block with EXT_CYC set to 6 and ROM_CYC left at 3. The two fixed costs therefore differ from each other and from the paged costs of 1 and 2, and a wrong region decode shows up as a wrong cycle count. Random accesses use only three pages and 8-bit offsets, so hits, page breaks, class changes and external-slot closures all occur often. Directed sequences pin down the ROM-leaves-state and shared-DRAM-mode cases.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        RGN_RAM    = 2'd0,
        RGN_ROMDRM = 2'd1,
        RGN_ROM    = 2'd2,
        RGN_EXT    = 2'd3
    } region_e;

    // access class used for page-hit comparison
    typedef enum logic [1:0] {
        CLS_FETCH = 2'd0,
        CLS_READ  = 2'd1,
        CLS_WRITE = 2'd2
    } acc_class_e;

    function automatic acc_class_e kind_to_class(input logic [1:0] kind);
        case (kind)
            ACC_FETCH: kind_to_class = CLS_FETCH;
            ACC_READ:  kind_to_class = CLS_READ;
            default:   kind_to_class = CLS_WRITE;
        endcase
    endfunction

    function automatic logic region_paged(input logic [1:0] rgn);
        region_paged = (rgn == RGN_RAM) || (rgn == RGN_ROMDRM);
    endfunction

endpackage

// File: rtl/pm_page_track.sv
module pm_page_track
    import pm_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [1:0]        kind,
    input  logic [PAGE_W-1:0] page,
    input  logic [1:0]        region,
    input  logic              force_break,
    output logic              hit
);

    typedef struct packed {
        logic              valid;
        logic [PAGE_W-1:0] page;
        acc_class_e        cls;
    } track_t;

    track_t st_d, st_q;
    acc_class_e cur_cls;

    always_comb begin
        cur_cls = kind_to_class(kind);
        hit     = st_q.valid && (st_q.page == page) && (st_q.cls == cur_cls)
                  && !force_break;
        st_d    = st_q;
        if (upd) begin
            case (region)
                RGN_RAM, RGN_ROMDRM: begin
                    st_d.valid = 1'b1;
                    st_d.page  = page;
                    st_d.cls   = cur_cls;
                end
                RGN_EXT: begin
                    st_d.valid = 1'b0;
                end
                default: begin
                    // internal ROM: open page untouched
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, page: '0, cls: CLS_FETCH};
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    ext_closes_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && region == RGN_EXT) |=> !st_q.valid);

    // R6
    rom_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && region == RGN_ROM) |=> (st_q == $past(st_q)));

endmodule

// File: rtl/pm_cost_calc.sv
module pm_cost_calc
    import pm_pkg::*;
#(
    parameter int ROM_CYC = 3,
    parameter int EXT_CYC = 5,
    parameter int CNT_W   = 4
) (
    input  logic             hit,
    input  logic [1:0]       region,
    input  logic             extra,
    output logic [CNT_W-1:0] cost
);

    logic [CNT_W-1:0] base;

    always_comb begin
        case (region)
            RGN_ROM: base = CNT_W'(ROM_CYC);
            RGN_EXT: base = CNT_W'(EXT_CYC);
            default: base = hit ? CNT_W'(1) : CNT_W'(2);
        endcase
        cost = base + (extra ? CNT_W'(1) : CNT_W'(0));
    end

endmodule

// File: rtl/pm_cycle_seq.sv
module pm_cycle_seq #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cost,
    input  logic             extra,
    output logic             busy,
    output logic             done,
    output logic             xfer
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             idle;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt  = cost;
            st_d.idle = extra;
        end else if (st_q.cnt != '0) begin
            st_d.cnt  = st_q.cnt - CNT_W'(1);
            st_d.idle = 1'b0;
        end
        busy = (st_q.cnt != '0);
        done = (st_q.cnt == CNT_W'(1));
        xfer = busy && !st_q.idle;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, idle: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R9
    idle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !xfer) |=> xfer);

endmodule

// File: rtl/pm_access_timer.sv
module pm_access_timer
    import pm_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int PAGE_W  = 8,
    parameter int ROM_CYC = 3,
    parameter int EXT_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_region,
    input  logic              req_extra,
    input  logic              force_break,
    output logic              busy,
    output logic              done,
    output logic              xfer
);

    localparam int MAX_FIX = (ROM_CYC > EXT_CYC) ? ROM_CYC : EXT_CYC;
    localparam int MAX_CYC = ((MAX_FIX > 2) ? MAX_FIX : 2) + 1;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             accept;
    logic             hit;
    logic [CNT_W-1:0] cost;

    assign accept = req_valid && !busy;

    pm_page_track #(.PAGE_W(PAGE_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd         (accept),
        .kind        (req_kind),
        .page        (req_addr[ADDR_W-1 -: PAGE_W]),
        .region      (req_region),
        .force_break (force_break),
        .hit         (hit)
    );

    pm_cost_calc #(
        .ROM_CYC (ROM_CYC),
        .EXT_CYC (EXT_CYC),
        .CNT_W   (CNT_W)
    ) u_cost (
        .hit    (hit),
        .region (req_region),
        .extra  (req_extra),
        .cost   (cost)
    );

    pm_cycle_seq #(.CNT_W(CNT_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .cost  (cost),
        .extra (req_extra),
        .busy  (busy),
        .done  (done),
        .xfer  (xfer)
    );

    // R2
    paged_cost_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && region_paged(req_region) && !req_extra)
            |-> (cost == CNT_W'(1) || cost == CNT_W'(2)));

    // R5
    forced_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && region_paged(req_region) && force_break) |-> !hit);

    // R11
    xfer_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> busy);

endmodule

// File: tb/tb_pm_access_timer.sv
module tb_pm_access_timer;

    localparam int EXT_C = 6;
    localparam int ROM_C = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_addr = 16'd0;
    logic [1:0]  req_region = 2'd0;
    logic        req_extra = 1'b0;
    logic        force_break = 1'b0;
    logic        busy, done, xfer;

    int checks = 0;
    int failures = 0;

    // bench model of the open page
    bit       m_valid = 1'b0;
    bit [7:0] m_page = 8'd0;
    int       m_cls = 0;

    always #5 clk = ~clk;

    pm_access_timer #(.ROM_CYC(ROM_C), .EXT_CYC(EXT_C)) dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_kind (req_kind),
        .req_addr (req_addr), .req_region (req_region), .req_extra (req_extra),
        .force_break (force_break), .busy (busy), .done (done), .xfer (xfer)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cls_of(input bit [1:0] k);
        return (k == 2'd0) ? 0 : (k == 2'd1) ? 1 : 2;
    endfunction

    function automatic int exp_cost(input bit [1:0] k, input bit [15:0] a,
                                    input bit [1:0] r, input bit ex, input bit fb);
        int c;
        if (r == 2'd2) c = ROM_C;
        else if (r == 2'd3) c = EXT_C;
        else if (m_valid && m_page == a[15:8] && m_cls == cls_of(k) && !fb) c = 1;
        else c = 2;
        return c + (ex ? 1 : 0);
    endfunction

    function automatic void model_upd(input bit [1:0] k, input bit [15:0] a, input bit [1:0] r);
        if (r == 2'd0 || r == 2'd1) begin
            m_valid = 1'b1; m_page = a[15:8]; m_cls = cls_of(k);
        end else if (r == 2'd3) begin
            m_valid = 1'b0;
        end
    endfunction

    // called at a negedge with the block idle
    task automatic access(input bit [1:0] k, input bit [15:0] a, input bit [1:0] r,
                          input bit ex, input bit fb, input bit spam, input string req);
        int e, n, xf;
        bit seen;
        e = exp_cost(k, a, r, ex, fb);
        model_upd(k, a, r);
        req_kind = k; req_addr = a; req_region = r; req_extra = ex;
        force_break = fb; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0; xf = 0; seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (busy) n++;
            if (xfer) xf++;
            if (ex && n == 1 && xfer) chk(1'b0, "R9 idle cycle xfer", 1, 0);
            if (done) begin seen = 1'b1; break; end
            if (spam) begin
                // R10: request while busy must be ignored
                req_valid = 1'b1; req_region = 2'd3; req_kind = 2'd2;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(seen && n == e, req, n, e);
        chk(xf == e - (ex ? 1 : 0), "R11 xfer cycles", xf, e - (ex ? 1 : 0));
        @(negedge clk);
        chk(!busy && !done, "R10 idle after done", {busy, done}, 0);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !xfer, "R1 reset outputs", {busy, done, xfer}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !xfer, "R1 idle after reset", {busy, done, xfer}, 0);

        access(2'd0, 16'h1234, 2'd0, 0, 0, 0, "R1 first access");
        access(2'd0, 16'h1235, 2'd0, 0, 0, 0, "R2 fetch hit");
        access(2'd0, 16'h12F0, 2'd0, 0, 0, 0, "R2 nonsequential hit");
        access(2'd0, 16'h1300, 2'd0, 0, 0, 0, "R3 new page");
        access(2'd1, 16'h1300, 2'd0, 0, 0, 0, "R4 fetch to read");
        access(2'd1, 16'h1301, 2'd0, 0, 0, 0, "R2 read hit");
        access(2'd2, 16'h1301, 2'd0, 0, 0, 0, "R4 read to write");
        access(2'd3, 16'h1302, 2'd0, 0, 0, 0, "R2 write hit kind3");
        access(2'd1, 16'h1303, 2'd0, 0, 0, 0, "R4 write to read");
        access(2'd0, 16'h1303, 2'd0, 0, 0, 0, "R4 read to fetch");
        access(2'd0, 16'h1304, 2'd0, 0, 1, 0, "R5 forced break");
        access(2'd1, 16'h2000, 2'd2, 0, 0, 0, "R6 rom cost");
        access(2'd1, 16'h2001, 2'd2, 0, 0, 0, "R6 rom same page");
        access(2'd0, 16'h1305, 2'd0, 0, 0, 0, "R6 rom leaves page");
        access(2'd1, 16'h2000, 2'd1, 0, 0, 0, "R7 dram mode break");
        access(2'd1, 16'h2001, 2'd1, 0, 0, 0, "R7 dram mode hit");
        access(2'd1, 16'h2002, 2'd0, 0, 0, 0, "R7 shared with ram");
        access(2'd1, 16'h4000, 2'd3, 0, 0, 0, "R8 ext cost");
        access(2'd1, 16'h2003, 2'd0, 0, 0, 0, "R8 ext closed page");
        access(2'd1, 16'h2004, 2'd0, 1, 0, 0, "R9 extra on hit");
        access(2'd2, 16'h2004, 2'd0, 1, 0, 0, "R9 extra on break");
        access(2'd2, 16'h2005, 2'd0, 0, 0, 1, "R10 busy request ignored");
        access(2'd2, 16'h2006, 2'd0, 0, 0, 0, "R10 state after ignored");

        for (int i = 0; i < 400; i++) begin
            bit [7:0] pg;
            bit [1:0] k, r;
            int sel;
            sel = int'($urandom % 3);
            pg = (sel == 0) ? 8'h10 : (sel == 1) ? 8'h11 : 8'hC0;
            k = 2'($urandom % 4);
            sel = int'($urandom % 10);
            r = (sel < 6) ? 2'd0 : (sel < 8) ? 2'd1 : (sel < 9) ? 2'd2 : 2'd3;
            access(k, {pg, 8'($urandom)}, r, ($urandom % 4) == 0,
                   ($urandom % 8) == 0, ($urandom % 16) == 0, "R2 R3 R4 random cost");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule